// File: doc/BRIEF.md
# Serial configuration memory read controller

This block is the read side of a one-bit-wide serial memory that streams a configuration bitstream into an FPGA loading itself in master serial mode. The FPGA supplies the clock, an active-low chip enable and one dual-role control input that acts as a counter reset at one level and as an output enable at the other. A bit pointer selects one location of a storage array. While the part is enabled, the selected bit is presented on the data output, and each rising clock edge moves the pointer to the next location.

A parameter sets whether the dual-role input resets when low (the default) or when high. A power-on reset input clears the pointer. A serial-enable input held low selects programming mode. In that mode the read path is locked out, and a simple synchronous load port, which stands in for the programming protocol, fills the array one bit per cycle. The output pad is modelled as a data bit plus a drive-enable. When the chip enable is high the block raises a standby indicator.

Top module: `cfgmem_rd`

## Requirements
- R1: While por_n is low the bit pointer is held at location 0. After por_n rises with the part enabled, the output shows location 0 before any clock edge.
- R2: While ser_en is high and rst_oe is at its reset level, the pointer is cleared at once, without waiting for a clock, and dout_oe is 0, whatever the level of ce_n.
- R3: With RST_HIGH=0, rst_oe low means reset and rst_oe high means output enable. With RST_HIGH=1 both meanings are swapped. The two settings behave identically when one is driven with the inverse of the other.
- R4: While ser_en is high and ce_n is 1, dout_oe is 0, standby is 1 and the pointer does not move. When ce_n returns to 0, output resumes at the same location.
- R5: dout_oe is 1 only while ser_en is 1, ce_n is 0 and rst_oe is at its enable level. In that state dout equals the bit stored at the pointer, and each rising clock edge advances the pointer by exactly one.
- R6: Once the pointer reaches location DEPTH-1 it stays there. Further edges keep presenting the last bit until the next reset.
- R7: While ser_en is 0, dout_oe is 0, standby is 0, ce_n has no effect and clock edges do not move the pointer. When ser_en returns to 1, output resumes at the same location.
- R8: On a rising edge with ld_we=1 and ser_en=0, ld_bit is written to location ld_addr. A write attempted while ser_en=1 leaves the array unchanged.
- R9: The ce_n level sampled at a rising edge decides whether that edge counts. A change of ce_n just after the edge has no effect on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock from the FPGA |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| rst_oe | input | 1 | Dual-role reset / output enable; polarity set by RST_HIGH |
| ser_en | input | 1 | 1 = read mode, 0 = programming mode |
| ld_we | input | 1 | Load write strobe |
| ld_addr | input | $clog2(DEPTH) | Load address |
| ld_bit | input | 1 | Load data bit |
| dout | output | 1 | Serial data bit (0 when not driven) |
| dout_oe | output | 1 | Drive enable for the data pad |
| standby | output | 1 | Low-power standby indicator |

## Verification
The bench fills a small array with a computed pattern and reads it out in full. It then keeps clocking past the end, so that a pointer that wraps instead of holding shows location 0 again. It asserts the reset level with chip enable both high and low, so that a design where chip enable gates the reset would keep a stale pointer. It pauses the stream through chip enable and through programming mode, and a design that counts or drives in either pause loses its place or drives the pad. It moves chip enable just after an edge, so that a design that samples late counts one location too few or too many. A second instance with the opposite reset polarity, driven with the inverted control input, must match the first on every check, which exposes a swapped polarity. A load attempted in read mode must not appear in the stream.

// File: rtl/cfgmem_rd.sv
module cfgmem_rd #(
  parameter int DEPTH    = 64,
  parameter bit RST_HIGH = 1'b0
) (
  input  logic                     clk,
  input  logic                     por_n,
  input  logic                     ce_n,
  input  logic                     rst_oe,
  input  logic                     ser_en,
  input  logic                     ld_we,
  input  logic [$clog2(DEPTH)-1:0] ld_addr,
  input  logic                     ld_bit,
  output logic                     dout,
  output logic                     dout_oe,
  output logic                     standby
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          mem [DEPTH];
  logic [AW-1:0] ptr;
  logic          rst_lvl, out_en, rd_ok, clr_n;

  assign rst_lvl = RST_HIGH ? rst_oe : ~rst_oe;
  assign out_en  = ~rst_lvl;
  assign rd_ok   = ser_en & ~ce_n & out_en;
  assign clr_n   = por_n & ~(ser_en & rst_lvl);

  always_ff @(posedge clk or negedge clr_n)
    if (!clr_n)                  ptr <= '0;
    else if (rd_ok && ptr != LAST) ptr <= ptr + 1'b1;

  always_ff @(posedge clk)
    if (!ser_en && ld_we) mem[ld_addr] <= ld_bit;

  assign dout_oe = rd_ok;
  assign dout    = rd_ok & mem[ptr];
  assign standby = ser_en & ce_n;
endmodule

// File: rtl/cfgmem_rd_chk.sv
module cfgmem_rd_chk #(
  parameter int DEPTH    = 64,
  parameter bit RST_HIGH = 1'b0
) (
  input logic                     clk,
  input logic                     por_n,
  input logic                     ce_n,
  input logic                     rst_oe,
  input logic                     ser_en,
  input logic                     dout_oe,
  input logic                     standby,
  input logic [$clog2(DEPTH)-1:0] ptr
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic rl;
  assign rl = RST_HIGH ? rst_oe : !rst_oe;

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    (ser_en && rl) |-> (ptr == '0 && !dout_oe)); // R2
  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!por_n)
    standby |-> !dout_oe); // R4
  AST_CE_FREEZE: assert property (@(posedge clk) disable iff (!por_n)
    (ser_en && ce_n && !rl) |=> (rl || ptr == $past(ptr))); // R4
  AST_PROG_LOCKOUT: assert property (@(posedge clk) disable iff (!por_n)
    !ser_en |-> (!dout_oe && !standby)); // R7
  AST_PROG_NO_COUNT: assert property (@(posedge clk) disable iff (!por_n)
    !ser_en |=> (ptr == $past(ptr) || ptr == '0)); // R7
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!por_n)
    (dout_oe && ptr != LAST) |=> (ptr == AW'($past(ptr) + 1'b1) || ptr == '0)); // R5
  AST_END_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (ptr == LAST) |=> (ptr == LAST || ptr == '0)); // R6
endmodule

bind cfgmem_rd cfgmem_rd_chk #(.DEPTH(DEPTH), .RST_HIGH(RST_HIGH)) u_chk (
  .clk(clk), .por_n(por_n), .ce_n(ce_n), .rst_oe(rst_oe), .ser_en(ser_en),
  .dout_oe(dout_oe), .standby(standby), .ptr(ptr)
);

// File: tb/tb_cfgmem_rd.sv
module tb_cfgmem_rd;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, por_n = 0, ce_n = 0, rst_oe = 1, ser_en = 0;
  logic ld_we = 0, ld_bit = 0;
  logic [AW-1:0] ld_addr = '0;
  logic d0, oe0, sb0, d1, oe1, sb1;
  int checks = 0, errors = 0;
  logic expv [DEPTH];

  always #4 clk = ~clk;

  cfgmem_rd #(.DEPTH(DEPTH), .RST_HIGH(1'b0)) dut (
    .clk(clk), .por_n(por_n), .ce_n(ce_n), .rst_oe(rst_oe), .ser_en(ser_en),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_bit(ld_bit),
    .dout(d0), .dout_oe(oe0), .standby(sb0));

  cfgmem_rd #(.DEPTH(DEPTH), .RST_HIGH(1'b1)) dut_hi (
    .clk(clk), .por_n(por_n), .ce_n(ce_n), .rst_oe(~rst_oe), .ser_en(ser_en),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_bit(ld_bit),
    .dout(d1), .dout_oe(oe1), .standby(sb1));

  function automatic logic pat(int a);
    return logic'((((a * 37 + 11) >> 3) ^ a) & 1);
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic expect_out(string tag, logic eo, logic ed, logic es);
    checks++;
    if (oe0 !== eo || sb0 !== es || (eo && d0 !== ed)) begin
      errors++;
      $display("FAIL %s: oe/dout/standby act %b/%b/%b exp %b/%b/%b", tag, oe0, d0, sb0, eo, ed, es);
    end
    checks++;
    if (oe1 !== oe0 || d1 !== d0 || sb1 !== sb0) begin
      errors++;
      $display("FAIL R3 (%s): inverted-polarity act %b/%b/%b exp %b/%b/%b", tag, oe1, d1, sb1, oe0, d0, sb0);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: act timeout exp finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    por_n = 1; #1;
    expect_out("R7 reset state prog mode", 0, 0, 0);

    // R8: fill array while ser_en low
    for (int a = 0; a < DEPTH; a++) begin
      ld_we = 1; ld_addr = AW'(a); ld_bit = pat(a); expv[a] = pat(a);
      tick();
    end
    ld_we = 0;

    // R8: write while ser_en high must be ignored
    ser_en = 1; rst_oe = 0; ld_we = 1; ld_addr = AW'(5); ld_bit = ~pat(5);
    tick(); tick();
    ld_we = 0;

    // R2: reset level with ce both ways
    ce_n = 1; #1; expect_out("R2 reset ce high", 0, 0, 1);
    ce_n = 0; #1; expect_out("R2 reset ce low", 0, 0, 0);
    tick(); expect_out("R2 reset after edge", 0, 0, 0);
    rst_oe = 1; #1;
    expect_out("R5 loc0 before edge", 1, expv[0], 0);

    // R5/R6/R8: full sweep and hold past end
    for (int k = 1; k < DEPTH + 4; k++) begin
      tick();
      expect_out(k < DEPTH ? "R5 sweep" : "R6 hold at end", 1, expv[k < DEPTH ? k : DEPTH-1], 0);
    end

    // R2: reset mid-stream (ce high) clears pointer immediately
    ce_n = 1; rst_oe = 0; #1;
    expect_out("R2 reset standby", 0, 0, 1);
    rst_oe = 1; ce_n = 0; #1;
    expect_out("R2 after reset loc0", 1, expv[0], 0);
    for (int k = 1; k <= 10; k++) tick();
    expect_out("R5 at 10", 1, expv[10], 0);

    // R4: chip enable high freezes
    ce_n = 1; #1; expect_out("R4 standby", 0, 0, 1);
    for (int k = 0; k < 5; k++) tick();
    expect_out("R4 standby held", 0, 0, 1);
    ce_n = 0; #1; expect_out("R4 resume", 1, expv[10], 0);

    // R9: ce raised just after an edge, that edge still counts
    tick(); ce_n = 1; #1;
    expect_out("R9 ce raised after edge", 0, 0, 1);
    tick(); tick();
    ce_n = 0; #1; expect_out("R9 counted edge", 1, expv[11], 0);
    // R9: ce high at edge, lowered after: edge not counted
    ce_n = 1; #1; tick(); ce_n = 0; #1;
    expect_out("R9 uncounted edge", 1, expv[11], 0);

    // R7: programming mode mid-stream
    tick(); expect_out("R5 at 12", 1, expv[12], 0);
    ser_en = 0; #1; expect_out("R7 prog lockout", 0, 0, 0);
    for (int k = 0; k < 6; k++) begin
      ce_n = k[0]; tick();
      expect_out("R7 prog ce ignored", 0, 0, 0);
    end
    ce_n = 0; ser_en = 1; #1;
    expect_out("R7 resume", 1, expv[12], 0);

    // R1: power-on reset mid-stream
    por_n = 0; #1; por_n = 1; #1;
    expect_out("R1 por to loc0", 1, expv[0], 0);
    tick(); expect_out("R1 then loc1", 1, expv[1], 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule